// File: doc/BRIEF.md
# Predicated Gather Prefetch Sequencer

This block takes a 32-bit vector gather-prefetch instruction word and turns it into a stream of prefetch requests. A start pulse makes it check the fixed bits of the word, split out the hint fields, immediate and register selectors, and take a snapshot of the supplied vector register and predicate register contents. It then steps through the lanes of the vector in ascending order. Each lane whose governing predicate bit is set produces one request. A request's address is the lane value, zero-extended to 64 bits, plus the 5-bit unsigned immediate. Lanes whose predicate bit is clear are skipped and cost no cycles.

The request leaves through a valid/ready port. The payload holds still while the port applies back-pressure, and the sequencer moves to the next active lane only on a cycle where valid and ready are both high. At most one request completes per clock. A single-cycle done pulse ends every operation. It also raises an error flag when the instruction word is malformed or the mode-block input was high at start. The vector length is a build-time parameter.

Top module: `gpf_seq`

## Requirements
- R1: A word is accepted only when bit 31 = 1, bits 29:21 = 9'b000100000, bits 15:13 = 3'b111 and bit 4 = 0. Any other value of those bits is rejected.
- R2: A rejected word, or `mode_block` high at start, gives `done` = 1 and `err` = 1 in the cycle after start. It issues no request and never raises `busy`.
- R3: An accepted word with no active lane gives `done` = 1 and `err` = 0 in the cycle after start, and issues no request.
- R4: A request address equals the lane value zero-extended to 64 bits plus `instr[20:16]`, taken modulo 2^64.
- R5: The hints are decoded from `instr[3:0]` as follows: `req_write` = bit 3 (0 is a read hint), `req_level` = bits 2:1, and `req_stream` = bit 0 (1 is non-temporal).
- R6: Lane e is active when `pred_data[e*(esize/8)]` is set. Inactive lanes issue nothing. Requests come out in ascending lane order.
- R7: `instr[30]` = 0 selects 32-bit lanes (VLEN/32 of them, lane e at `vec_data[32e+31:32e]`). `instr[30]` = 1 selects 64-bit lanes (VLEN/64 of them, lane e at `vec_data[64e+63:64e]`).
- R8: While `req_valid` is high and `req_ready` is low, the valid signal and every payload field stay unchanged into the next cycle.
- R9: After reset all outputs are idle. `busy` is high from the cycle after an accepted start with active lanes until the last handshake. `done` is a one-cycle pulse in the following cycle, with `busy` low. A start while `busy` is high is ignored.
- R10: `pred_sel` = `instr[12:10]` and `vec_sel` = `instr[9:5]` of the accepted word, held stable for as long as `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation with the current inputs |
| instr | input | 32 | Instruction word |
| mode_block | input | 1 | When high at start, forces the error outcome |
| vec_data | input | VLEN | Base vector register contents |
| pred_data | input | VLEN/8 | Governing predicate contents |
| req_ready | input | 1 | Prefetch port can accept a request |
| req_valid | output | 1 | Request payload is valid |
| req_addr | output | 64 | Prefetch byte address |
| req_write | output | 1 | 1 = store hint, 0 = load hint |
| req_level | output | 2 | Target cache level code |
| req_stream | output | 1 | Non-temporal hint |
| busy | output | 1 | Sequencer is issuing lanes |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | With done: operation rejected |
| pred_sel | output | 3 | Predicate register index of the operation |
| vec_sel | output | 5 | Vector register index of the operation |

## Verification
The hardest case to reach from the ports combines three things. Back-pressure stalls the final active lane. A fresh start pulse, carrying different instruction, vector and predicate values, arrives while the sequencer is still busy. The predicate sets only bits that are not the lowest of a lane's byte group. The stimulus drives `req_ready` randomly at a 3/4 rate and fires stray start strobes with scrambled inputs during busy cycles. It mixes random predicate densities with directed patterns that are active for one element size but idle for the other. Directed all-ones lanes with immediate 31 cover the address carry into bit 32 and the 64-bit wrap.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
  localparam logic [31:0] FIX_MASK = 32'hBFE0_E010;
  localparam logic [31:0] FIX_VAL  = 32'h8400_E000;

  typedef struct packed {
    logic       wr;
    logic [1:0] lvl;
    logic       strm;
  } pf_hint_t;

  typedef struct packed {
    logic       ok;
    logic       es64;
    logic [4:0] imm;
    logic [2:0] psel;
    logic [4:0] vsel;
    pf_hint_t   hint;
  } pf_dec_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_st_t;
endpackage

// File: rtl/gpf_decode.sv
module gpf_decode
  import gpf_pkg::*;
(
  input  logic [31:0] instr,
  output pf_dec_t     dec
);
  always_comb begin
    dec.ok        = (instr & FIX_MASK) == FIX_VAL;
    dec.es64      = instr[30];
    dec.imm       = instr[20:16];
    dec.psel      = instr[12:10];
    dec.vsel      = instr[9:5];
    dec.hint.wr   = instr[3];
    dec.hint.lvl  = instr[2:1];
    dec.hint.strm = instr[0];
  end
endmodule

// File: rtl/gpf_lane_pick.sv
module gpf_lane_pick #(
  parameter int NL = 8,
  localparam int IW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [NL-1:0] pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/gpf_lane_addr.sv
module gpf_lane_addr #(
  parameter int VLEN = 256,
  localparam int NL32 = VLEN / 32,
  localparam int NL64 = VLEN / 64,
  localparam int IW = (NL32 > 1) ? $clog2(NL32) : 1
) (
  input  logic [VLEN-1:0] vec,
  input  logic            es64,
  input  logic [IW-1:0]   idx,
  input  logic [4:0]      imm,
  output logic [63:0]     addr
);
  logic [31:0] w32 [NL32];
  logic [63:0] w64 [NL64];
  logic [31:0] sel32;
  logic [63:0] sel64;

  for (genvar g = 0; g < NL32; g++) begin : g_w32
    assign w32[g] = vec[g*32 +: 32];
  end
  for (genvar g = 0; g < NL64; g++) begin : g_w64
    assign w64[g] = vec[g*64 +: 64];
  end

  always_comb begin
    sel32 = '0;
    for (int g = 0; g < NL32; g++) begin
      if (idx == IW'(g)) sel32 = w32[g];
    end
    sel64 = '0;
    for (int g = 0; g < NL64; g++) begin
      if (idx == IW'(g)) sel64 = w64[g];
    end
  end

  assign addr = (es64 ? sel64 : {32'd0, sel32}) + {59'd0, imm};
endmodule

// File: rtl/gpf_seq.sv
module gpf_seq
  import gpf_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic              mode_block,
  input  logic [VLEN-1:0]   vec_data,
  input  logic [VLEN/8-1:0] pred_data,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [63:0]       req_addr,
  output logic              req_write,
  output logic [1:0]        req_level,
  output logic              req_stream,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        pred_sel,
  output logic [4:0]        vec_sel
);
  localparam int NL32 = VLEN / 32;
  localparam int NL64 = VLEN / 64;
  localparam int IW   = (NL32 > 1) ? $clog2(NL32) : 1;

  pf_dec_t        dec;
  seq_st_t        st_q;
  logic [NL32-1:0] act32, act64, lane_mask;
  logic [NL32-1:0] pend_q, pend_nxt;
  logic [VLEN-1:0] vec_q;
  logic            es64_q, err_q;
  logic [4:0]      imm_q, vsel_q;
  logic [2:0]      psel_q;
  pf_hint_t        hint_q;
  logic            pend_any;
  logic [IW-1:0]   cur_idx;
  logic            launch, accept, fire;

  gpf_decode u_dec (.instr(instr), .dec(dec));

  // lane activity from the lowest bit of each lane's predicate byte group
  for (genvar e = 0; e < NL32; e++) begin : g_act
    assign act32[e] = pred_data[e*4];
    if (e < NL64) begin : g_wide
      assign act64[e] = pred_data[e*8];
    end else begin : g_none
      assign act64[e] = 1'b0;
    end
  end

  assign lane_mask = dec.es64 ? act64 : act32;
  assign launch    = start && (st_q != S_RUN);
  assign accept    = dec.ok && !mode_block;

  gpf_lane_pick #(.NL(NL32)) u_pick (
    .pend (pend_q),
    .any  (pend_any),
    .idx  (cur_idx)
  );

  gpf_lane_addr #(.VLEN(VLEN)) u_addr (
    .vec  (vec_q),
    .es64 (es64_q),
    .idx  (cur_idx),
    .imm  (imm_q),
    .addr (req_addr)
  );

  assign req_valid = (st_q == S_RUN) && pend_any;
  assign fire      = req_valid && req_ready;
  assign pend_nxt  = pend_q & ~(NL32'(1) << cur_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      err_q  <= 1'b0;
      es64_q <= 1'b0;
      imm_q  <= '0;
      psel_q <= '0;
      vsel_q <= '0;
      hint_q <= '0;
    end else if (launch) begin
      psel_q <= dec.psel;
      vsel_q <= dec.vsel;
      es64_q <= dec.es64;
      imm_q  <= dec.imm;
      hint_q <= dec.hint;
      if (!accept) begin
        st_q   <= S_FIN;
        err_q  <= 1'b1;
        pend_q <= '0;
      end else begin
        err_q  <= 1'b0;
        pend_q <= lane_mask;
        st_q   <= (|lane_mask) ? S_RUN : S_FIN;
      end
    end else begin
      case (st_q)
        S_RUN: begin
          if (fire) begin
            pend_q <= pend_nxt;
            if (pend_nxt == '0) st_q <= S_FIN;
          end else if (!pend_any) begin
            st_q <= S_FIN;
          end
        end
        S_FIN: begin
          st_q  <= S_IDLE;
          err_q <= 1'b0;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // the base vector is only captured when at least one lane will use it
  always_ff @(posedge clk) begin
    if (launch && accept && (|lane_mask)) vec_q <= vec_data;
  end

  assign req_write  = hint_q.wr;
  assign req_level  = hint_q.lvl;
  assign req_stream = hint_q.strm;
  assign busy       = (st_q == S_RUN);
  assign done       = (st_q == S_FIN);
  assign err        = (st_q == S_FIN) && err_q;
  assign pred_sel   = psel_q;
  assign vec_sel    = vsel_q;
endmodule

// File: rtl/gpf_seq_chk.sv
module gpf_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        req_write,
  input logic [1:0]  req_level,
  input logic        req_stream,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [2:0]  pred_sel,
  input logic [4:0]  vec_sel
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
      && $stable(req_level) && $stable(req_stream));

  p_stall_keeps_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_ready |=> busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !req_valid && !busy);

  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || ($stable(vec_sel) && $stable(pred_sel)));
endmodule

bind gpf_seq gpf_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .req_level  (req_level),
  .req_stream (req_stream),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .pred_sel   (pred_sel),
  .vec_sel    (vec_sel)
);

// File: tb/sim_gpf_seq.sv
module sim_gpf_seq;
  localparam int VLEN = 256;
  localparam int NL   = VLEN / 32;
  localparam int PB   = VLEN / 8;
  localparam logic [31:0] FMASK = 32'hBFE0_E010;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     instr = '0;
  logic            mode_block = 1'b0;
  logic [VLEN-1:0] vec_data = '0;
  logic [PB-1:0]   pred_data = '0;
  logic            req_ready = 1'b0;
  logic            req_valid, req_write, req_stream, busy, done, err;
  logic [63:0]     req_addr;
  logic [1:0]      req_level;
  logic [2:0]      pred_sel;
  logic [4:0]      vec_sel;

  always #2 clk = ~clk;

  gpf_seq #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mode_block(mode_block),
    .vec_data(vec_data), .pred_data(pred_data), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_level(req_level), .req_stream(req_stream), .busy(busy), .done(done),
    .err(err), .pred_sel(pred_sel), .vec_sel(vec_sel)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input bit es64, input logic [4:0] imm,
      input logic [2:0] pg, input logic [4:0] zn, input logic [3:0] op);
    return {1'b1, es64, 9'b000100000, imm, 3'b111, pg, zn, 1'b0, op};
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    logic [VLEN-1:0] v;
    for (int w = 0; w < NL; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic run_op(input logic [31:0] ins, input bit blk,
      input logic [VLEN-1:0] v, input logic [PB-1:0] p);
    logic [63:0] exp_a [NL];
    int n, cnt, cyc, nl, step;
    bit ok, es64, pv, pr;
    logic [63:0] pa;
    logic [63:0] lane;
    ok   = ((ins & FMASK) == 32'h8400_E000) && !blk;
    es64 = ins[30];
    nl   = es64 ? VLEN / 64 : VLEN / 32;
    step = es64 ? 8 : 4;
    n = 0;
    for (int e = 0; e < nl; e++) begin
      if (p[e*step]) begin
        lane = es64 ? v[e*64 +: 64] : {32'd0, v[e*32 +: 32]};
        exp_a[n] = lane + {59'd0, ins[20:16]};
        n++;
      end
    end

    @(negedge clk);
    instr = ins; mode_block = blk; vec_data = v; pred_data = p; start = 1'b1;
    req_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (!ok) begin
      chk(done && err && !req_valid && !busy, "R2 reject outcome", {60'd0, done, err, req_valid, busy}, 64'hC);
    end else if (n == 0) begin
      chk(done && !err && !req_valid, "R3 no active lane", {61'd0, done, err, req_valid}, 64'h4);
    end else begin
      chk(busy && !done, "R9 busy after start", {62'd0, busy, done}, 64'h2);
      chk(vec_sel == ins[9:5] && pred_sel == ins[12:10], "R10 selectors",
          {56'd0, pred_sel, vec_sel}, {56'd0, ins[12:10], ins[9:5]});
      cnt = 0; cyc = 0; pv = 0; pr = 0; pa = '0;
      while (!done && cyc < 400) begin
        if (pv && !pr) chk(req_valid && req_addr == pa, "R8 hold under stall", req_addr, pa);
        if (busy) chk(vec_sel == ins[9:5] && pred_sel == ins[12:10], "R10 held", {59'd0, vec_sel}, {59'd0, ins[9:5]});
        if (req_valid) begin
          if (cnt < n) chk(req_addr == exp_a[cnt], "R4 R6 R7 address order", req_addr, exp_a[cnt]);
          else chk(1'b0, "R6 extra request", {63'd0, req_valid}, 64'd0);
          chk({req_write, req_level, req_stream} == ins[3:0], "R5 hint fields",
              {60'd0, req_write, req_level, req_stream}, {60'd0, ins[3:0]});
        end
        pv = req_valid; pa = req_addr;
        pr = (($urandom % 4) != 0);
        req_ready = pr;
        if (req_valid && pr) cnt++;
        if (($urandom % 5) == 0) begin
          start = 1'b1; instr = $urandom; vec_data = rnd_vec(); pred_data = '0; mode_block = $urandom % 2;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        cyc++;
      end
      start = 1'b0; req_ready = 1'b0;
      chk(done && !busy && !err, "R9 done pulse", {61'd0, done, busy, err}, 64'h4);
      chk(cnt == n, "R6 request count", 64'(cnt), 64'(n));
    end
    @(negedge clk);
    chk(!done && !err, "R9 single cycle done", {62'd0, done, err}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ins;
    logic [PB-1:0] p;
    int pos;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_valid && !err, "R9 reset state", {60'd0, busy, done, req_valid, err}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !req_valid && !err, "R9 idle after reset", {60'd0, busy, done, req_valid, err}, 64'd0);

    // R4: 64-bit wrap and carry beyond 32 bits
    run_op(mk_instr(1, 5'd31, 3'd2, 5'd9, 4'b1011), 0, '1, '1);
    run_op(mk_instr(0, 5'd31, 3'd7, 5'd31, 4'b0100), 0, '1, '1);
    // R6 R7: predicate bits that are active only for one lane size
    run_op(mk_instr(1, 5'd3, 3'd1, 5'd4, 4'b0001), 0, rnd_vec(), 32'h1010_1010);
    run_op(mk_instr(0, 5'd3, 3'd1, 5'd4, 4'b0001), 0, rnd_vec(), 32'h1010_1010);
    run_op(mk_instr(0, 5'd0, 3'd0, 5'd0, 4'b0000), 0, rnd_vec(), 32'hEEEE_EEEE);
    // R3: empty predicate
    run_op(mk_instr(1, 5'd7, 3'd5, 5'd2, 4'b1110), 0, rnd_vec(), '0);
    // R1 R2: fixed-bit violations and blocked mode
    run_op(mk_instr(0, 5'd1, 3'd1, 5'd1, 4'b0000) | 32'h10, 0, rnd_vec(), '1);
    run_op(mk_instr(0, 5'd1, 3'd1, 5'd1, 4'b0000) & ~32'h8000, 0, rnd_vec(), '1);
    run_op(mk_instr(1, 5'd1, 3'd1, 5'd1, 4'b0000), 1, rnd_vec(), '1);
    // R5: every hint code
    for (int op = 0; op < 16; op++)
      run_op(mk_instr(op % 2, 5'(op), 3'(op), 5'(op), 4'(op)), 0, rnd_vec(), PB'($urandom));

    for (int k = 0; k < 300; k++) begin
      ins = mk_instr($urandom % 2, 5'($urandom), 3'($urandom), 5'($urandom), 4'($urandom));
      if (($urandom % 10) == 0) begin
        do pos = $urandom % 32; while (!FMASK[pos]);
        ins = ins ^ (32'd1 << pos);
      end
      case ($urandom % 4)
        0: p = '0;
        1: p = '1;
        2: p = PB'($urandom);
        default: p = PB'($urandom & $urandom & $urandom);
      endcase
      run_op(ins, ($urandom % 12) == 0, rnd_vec(), p);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule